// File: doc/BRIEF.md
# Embedded Operation Status Word Generator

This block builds the byte that a flash-style memory returns to the host while an internal program or erase operation is running, in place of array contents. A command decoder upstream hands it single-cycle events: start a byte program, start a sector or whole-device erase, add another sector during the erase accumulation window, suspend, resume, and a reset command. The block keeps a small model of the internal operation and its phase. This model covers the operation kind, a countdown whose lengths are set by parameters, the sector accumulation window, suspension, timeout and the set of sectors chosen for erase.

On every host read the block presents either the array byte from its input or a status byte. In that status byte, bit 7 is a data-polling bit and bit 6 is a global toggle that flips on each status read. Bit 5 flags a timeout. Bit 3 shows whether the accumulation window has closed. Bit 2 is a per-sector toggle that only moves on reads to sectors being erased. Operations aimed only at protected sectors toggle briefly and then fall back to read mode. A fail input forces the timeout path, so host polling software can be exercised.

Top module: `stw_status`

## Requirements
- R1: After reset, and whenever no operation is in progress, `dout_o` equals `array_i` and `stat_o` is 0.
- R2: During a program (active, aborted or timed out), bit 7 of the status byte is the inverse of bit 7 of the latched program data, and bit 2 reads 0.
- R3: Bit 6 starts at 0 when an operation starts and inverts after each read (`rd_i` high at a clock edge) while programming, in the window, erasing, aborting or timed out. It holds its value while suspended.
- R4: If `fail_i` is high when a program or erase countdown expires, the block enters a timeout state in which bit 5 reads 1. In that state it ignores every command except the reset command, which returns it to read mode.
- R5: Bit 3 reads 0 while the erase accumulation window is open. It reads 1 once the erase has begun, and also while suspended, in an all-protected erase abort and in an erase timeout.
- R6: Bit 2 starts at 0 and inverts after each read of a sector selected for erase. Reads of unselected sectors show bit 2 as 0 and leave it unchanged. While suspended, reads of unselected sectors return `array_i` with `stat_o` 0.
- R7: A program to a sector whose `prot_i` bit is 1, or an erase whose chosen sectors are all protected, shows status for ABORT_CYC cycles and then returns to read mode.
- R8: A program lasts PROG_CYC cycles and the erase itself lasts ERASE_CYC cycles, not counting time spent suspended. The sector window lasts WIN_CYC cycles and restarts on each added sector. A whole-device erase skips the window. On success the block returns to read mode by itself.
- R9: Suspend during the window or the erase enters the suspended state, and resume returns to erasing. Suspend and resume have no effect in any other state.
- R10: During an erase, bit 7 reads 0 except while suspended, where it reads 1. Bits 4, 1 and 0 of every status byte read 0.
- R11: A program command or a whole-device erase command during the window ends the window and returns the block to read mode without starting anything. A reset command during the window does the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_i | input | 1 | Start-program event |
| prog_sect_i | input | SECT_W | Sector of the program address |
| prog_data_i | input | 8 | Byte being programmed |
| erase_i | input | 1 | Erase event (start, or add a sector) |
| erase_chip_i | input | 1 | With erase_i: erase every sector |
| erase_sect_i | input | SECT_W | Sector for a sector erase |
| suspend_i | input | 1 | Erase-suspend event |
| resume_i | input | 1 | Erase-resume event |
| reset_i | input | 1 | Reset-command event |
| fail_i | input | 1 | Force the timeout path at countdown expiry |
| prot_i | input | NSECT | Per-sector protection flags |
| rd_i | input | 1 | Host read strobe |
| rd_sect_i | input | SECT_W | Sector of the read address |
| array_i | input | 8 | Array data for the read address |
| dout_o | output | 8 | Byte returned to the host |
| stat_o | output | 1 | High when dout_o carries status |

## Verification
The assertions assume that command events are single-cycle pulses, that at most one of them is high in any cycle, and that sector indices stay below NSECT. They also assume every cycle-count parameter is at least one. The stimulus meets these conditions by driving each event from a task that raises exactly one input on a falling edge and lowers it on the next. The bench uses a four-sector configuration with short counts, so that every state and every expiry edge is reached within a few dozen cycles.

// File: rtl/stw_pkg.sv
package stw_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_PROG,
        S_WIN,
        S_ERASE,
        S_SUSP,
        S_ABORT,
        S_FAIL
    } stw_state_e;
endpackage

// File: rtl/stw_timer.sv
module stw_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] val_i,
    input  logic          run_i,
    output logic          zero_o
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (run_i && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/stw_ctrl.sv
module stw_ctrl
    import stw_pkg::*;
#(
    parameter int NSECT     = 8,
    parameter int SW        = 3,
    parameter int TW        = 8,
    parameter int PROG_CYC  = 64,
    parameter int ERASE_CYC = 1024,
    parameter int WIN_CYC   = 128,
    parameter int ABORT_CYC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_i,
    input  logic [SW-1:0]    prog_sect_i,
    input  logic [7:0]       prog_data_i,
    input  logic             erase_i,
    input  logic             erase_chip_i,
    input  logic [SW-1:0]    erase_sect_i,
    input  logic             suspend_i,
    input  logic             resume_i,
    input  logic             reset_i,
    input  logic             fail_i,
    input  logic [NSECT-1:0] prot_i,
    input  logic             tmr_zero_i,
    output stw_state_e       state_o,
    output logic             erase_kind_o,
    output logic             pd7_o,
    output logic [NSECT-1:0] sel_o,
    output logic             tmr_load_o,
    output logic [TW-1:0]    tmr_val_o,
    output logic             tmr_run_o
);
    localparam logic [TW-1:0] PROG_LD  = TW'(PROG_CYC - 1);
    localparam logic [TW-1:0] ERASE_LD = TW'(ERASE_CYC - 1);
    localparam logic [TW-1:0] WIN_LD   = TW'(WIN_CYC - 1);
    localparam logic [TW-1:0] ABORT_LD = TW'(ABORT_CYC - 1);

    typedef struct packed {
        stw_state_e       st;
        logic             erase_kind;
        logic             pd7;
        logic [NSECT-1:0] sel;
    } ctrl_t;

    ctrl_t d, q;
    logic [NSECT-1:0] req_sel, req_free;

    always_comb begin
        d          = q;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        req_sel    = erase_chip_i ? {NSECT{1'b1}} : (NSECT'(1) << erase_sect_i);
        req_free   = req_sel & ~prot_i;

        case (q.st)
            S_IDLE: begin
                if (prog_i) begin
                    d.erase_kind = 1'b0;
                    d.pd7        = prog_data_i[7];
                    tmr_load_o   = 1'b1;
                    if (prot_i[prog_sect_i]) begin
                        d.st      = S_ABORT;
                        tmr_val_o = ABORT_LD;
                    end else begin
                        d.st      = S_PROG;
                        tmr_val_o = PROG_LD;
                    end
                end else if (erase_i) begin
                    d.erase_kind = 1'b1;
                    d.sel        = req_free;
                    tmr_load_o   = 1'b1;
                    if (!erase_chip_i) begin
                        d.st      = S_WIN;
                        tmr_val_o = WIN_LD;
                    end else if (req_free == '0) begin
                        d.st      = S_ABORT;
                        tmr_val_o = ABORT_LD;
                    end else begin
                        d.st      = S_ERASE;
                        tmr_val_o = ERASE_LD;
                    end
                end
            end
            S_PROG: begin
                if (tmr_zero_i) d.st = fail_i ? S_FAIL : S_IDLE;
            end
            S_WIN: begin
                if (reset_i || prog_i || (erase_i && erase_chip_i)) begin
                    d.st = S_IDLE;
                end else if (suspend_i) begin
                    tmr_load_o = 1'b1;
                    if (q.sel == '0) begin
                        d.st      = S_ABORT;
                        tmr_val_o = ABORT_LD;
                    end else begin
                        d.st      = S_SUSP;
                        tmr_val_o = ERASE_LD;
                    end
                end else if (erase_i) begin
                    d.sel      = q.sel | req_free;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = WIN_LD;
                end else if (tmr_zero_i) begin
                    tmr_load_o = 1'b1;
                    if (q.sel == '0) begin
                        d.st      = S_ABORT;
                        tmr_val_o = ABORT_LD;
                    end else begin
                        d.st      = S_ERASE;
                        tmr_val_o = ERASE_LD;
                    end
                end
            end
            S_ERASE: begin
                if (suspend_i)       d.st = S_SUSP;
                else if (tmr_zero_i) d.st = fail_i ? S_FAIL : S_IDLE;
            end
            S_SUSP: begin
                if (resume_i) d.st = S_ERASE;
            end
            S_ABORT: begin
                if (tmr_zero_i) d.st = S_IDLE;
            end
            S_FAIL: begin
                if (reset_i) d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase

        if (d.st == S_IDLE) d.sel = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: S_IDLE, erase_kind: 1'b0, pd7: 1'b0, sel: '0};
        else        q <= d;
    end

    assign state_o      = q.st;
    assign erase_kind_o = q.erase_kind;
    assign pd7_o        = q.pd7;
    assign sel_o        = q.sel;
    assign tmr_run_o    = (q.st == S_PROG) || (q.st == S_WIN) ||
                          (q.st == S_ERASE) || (q.st == S_ABORT);
endmodule

// File: rtl/stw_fmt.sv
module stw_fmt
    import stw_pkg::*;
#(
    parameter int NSECT = 8,
    parameter int SW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  stw_state_e       state_i,
    input  logic             erase_kind_i,
    input  logic             pd7_i,
    input  logic [NSECT-1:0] sel_i,
    input  logic             rd_i,
    input  logic [SW-1:0]    rd_sect_i,
    input  logic [7:0]       array_i,
    output logic [7:0]       dout_o,
    output logic             stat_o,
    output logic             tog6_o
);
    typedef struct packed {
        logic t6;
        logic t2;
    } tog_t;

    tog_t d, q;
    logic hit, run6, run2;
    logic [7:0] word;

    always_comb begin
        hit  = sel_i[rd_sect_i];
        run6 = (state_i != S_IDLE) && (state_i != S_SUSP);
        run2 = erase_kind_i && hit && (state_i != S_IDLE);

        d = q;
        if (state_i == S_IDLE) begin
            d = '0;
        end else if (rd_i) begin
            d.t6 = q.t6 ^ run6;
            d.t2 = q.t2 ^ run2;
        end

        word    = '0;
        word[7] = (state_i == S_SUSP) ? 1'b1 : (erase_kind_i ? 1'b0 : ~pd7_i);
        word[6] = q.t6;
        word[5] = (state_i == S_FAIL);
        word[3] = erase_kind_i && (state_i != S_WIN);
        word[2] = run2 && q.t2;

        stat_o = (state_i != S_IDLE) && !((state_i == S_SUSP) && !hit);
        dout_o = stat_o ? word : array_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tog6_o = q.t6;
endmodule

// File: rtl/stw_status.sv
module stw_status
    import stw_pkg::*;
#(
    parameter int NSECT     = 8,
    parameter int SECT_W    = $clog2(NSECT),
    parameter int PROG_CYC  = 64,
    parameter int ERASE_CYC = 1024,
    parameter int WIN_CYC   = 128,
    parameter int ABORT_CYC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_i,
    input  logic [SECT_W-1:0] prog_sect_i,
    input  logic [7:0]        prog_data_i,
    input  logic              erase_i,
    input  logic              erase_chip_i,
    input  logic [SECT_W-1:0] erase_sect_i,
    input  logic              suspend_i,
    input  logic              resume_i,
    input  logic              reset_i,
    input  logic              fail_i,
    input  logic [NSECT-1:0]  prot_i,
    input  logic              rd_i,
    input  logic [SECT_W-1:0] rd_sect_i,
    input  logic [7:0]        array_i,
    output logic [7:0]        dout_o,
    output logic              stat_o
);
    localparam int MAX_PE = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int MAX_WA = (WIN_CYC > ABORT_CYC) ? WIN_CYC : ABORT_CYC;
    localparam int MAXC   = (MAX_PE > MAX_WA) ? MAX_PE : MAX_WA;
    localparam int TW     = $clog2(MAXC + 1);

    stw_state_e        st_w;
    logic              kind_w, pd7_w, zero_w, load_w, run_w, tog6_w;
    logic [NSECT-1:0]  sel_w;
    logic [TW-1:0]     val_w;

    stw_ctrl #(
        .NSECT(NSECT), .SW(SECT_W), .TW(TW),
        .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
        .WIN_CYC(WIN_CYC), .ABORT_CYC(ABORT_CYC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .prog_i(prog_i), .prog_sect_i(prog_sect_i), .prog_data_i(prog_data_i),
        .erase_i(erase_i), .erase_chip_i(erase_chip_i), .erase_sect_i(erase_sect_i),
        .suspend_i(suspend_i), .resume_i(resume_i), .reset_i(reset_i),
        .fail_i(fail_i), .prot_i(prot_i), .tmr_zero_i(zero_w),
        .state_o(st_w), .erase_kind_o(kind_w), .pd7_o(pd7_w), .sel_o(sel_w),
        .tmr_load_o(load_w), .tmr_val_o(val_w), .tmr_run_o(run_w)
    );

    stw_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load_i(load_w), .val_i(val_w),
        .run_i(run_w), .zero_o(zero_w)
    );

    stw_fmt #(.NSECT(NSECT), .SW(SECT_W)) u_fmt (
        .clk(clk), .rst_n(rst_n), .state_i(st_w), .erase_kind_i(kind_w),
        .pd7_i(pd7_w), .sel_i(sel_w), .rd_i(rd_i), .rd_sect_i(rd_sect_i),
        .array_i(array_i), .dout_o(dout_o), .stat_o(stat_o), .tog6_o(tog6_w)
    );
endmodule

// File: rtl/stw_status_chk.sv
module stw_status_chk
    import stw_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input stw_state_e st,
    input logic       tog6,
    input logic       rd_i,
    input logic       resume_i,
    input logic       reset_i,
    input logic       stat_o,
    input logic [7:0] dout_o,
    input logic [7:0] array_i
);
    a_r1_idle_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE) |-> (!stat_o && dout_o == array_i));

    a_r3_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && st != S_IDLE && st != S_SUSP) |=> (tog6 != $past(tog6)));

    a_r3_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SUSP) |=> $stable(tog6));

    a_r5_window_bit3_low: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o && st == S_WIN) |-> !dout_o[3]);

    a_r10_unused_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        stat_o |-> (!dout_o[4] && dout_o[1:0] == 2'b00));

    a_r4_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_FAIL && !reset_i) |=> (st == S_FAIL && dout_o[5]));

    a_r9_resume_erases: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SUSP && resume_i) |=> (st == S_ERASE));
endmodule

bind stw_status stw_status_chk u_chk (
    .clk(clk), .rst_n(rst_n), .st(st_w), .tog6(tog6_w), .rd_i(rd_i),
    .resume_i(resume_i), .reset_i(reset_i), .stat_o(stat_o),
    .dout_o(dout_o), .array_i(array_i)
);

// File: tb/tb_stw_status.sv
module tb_stw_status;
    localparam int NS = 4;
    localparam int SW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_i = 0, erase_i = 0, erase_chip_i = 0;
    logic suspend_i = 0, resume_i = 0, reset_i = 0, fail_i = 0, rd_i = 0;
    logic [SW-1:0] prog_sect_i = '0, erase_sect_i = '0, rd_sect_i = '0;
    logic [7:0] prog_data_i = '0, array_i = 8'h5A;
    logic [NS-1:0] prot_i = '0;
    logic [7:0] dout_o;
    logic stat_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    stw_status #(
        .NSECT(NS), .PROG_CYC(5), .ERASE_CYC(8), .WIN_CYC(4), .ABORT_CYC(3)
    ) dut (
        .clk(clk), .rst_n(rst_n), .prog_i(prog_i), .prog_sect_i(prog_sect_i),
        .prog_data_i(prog_data_i), .erase_i(erase_i), .erase_chip_i(erase_chip_i),
        .erase_sect_i(erase_sect_i), .suspend_i(suspend_i), .resume_i(resume_i),
        .reset_i(reset_i), .fail_i(fail_i), .prot_i(prot_i), .rd_i(rd_i),
        .rd_sect_i(rd_sect_i), .array_i(array_i), .dout_o(dout_o), .stat_o(stat_o)
    );

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // read: sample {stat, dout}; exp_stat selects status or array expectation
    task automatic rd(input logic [SW-1:0] s, input logic st, input logic [7:0] exp, input string req);
        rd_i = 1'b1;
        rd_sect_i = s;
        #1;
        check(req, {stat_o, dout_o}, {st, st ? exp : array_i});
        @(negedge clk);
        rd_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_prog(input logic [SW-1:0] s, input logic [7:0] dat);
        prog_i = 1'b1; prog_sect_i = s; prog_data_i = dat;
        @(negedge clk);
        prog_i = 1'b0;
    endtask

    task automatic do_erase(input logic chip, input logic [SW-1:0] s);
        erase_i = 1'b1; erase_chip_i = chip; erase_sect_i = s;
        @(negedge clk);
        erase_i = 1'b0; erase_chip_i = 1'b0;
    endtask

    task automatic do_susp();
        suspend_i = 1'b1; @(negedge clk); suspend_i = 1'b0;
    endtask

    task automatic do_resume();
        resume_i = 1'b1; @(negedge clk); resume_i = 1'b0;
    endtask

    task automatic do_reset();
        reset_i = 1'b1; @(negedge clk); reset_i = 1'b0;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(2);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state passes array data
        rd(0, 0, 8'h00, "R1 reset passthrough");
        array_i = 8'hC3;
        rd(2, 0, 8'h00, "R1 passthrough new value");

        // R2 R3 R8: program with data bit7=1, five status reads then array
        array_i = 8'h3C;
        do_prog(1, 8'h80);
        for (int k = 0; k < 5; k++)
            rd(1, 1, (k % 2) ? 8'h40 : 8'h00, "R2 R3 R8 program status");
        rd(1, 0, 8'h00, "R8 program auto return");

        // R2: data bit7=0 gives bit7=1 while busy
        do_prog(0, 8'h55);
        rd(0, 1, 8'h80, "R2 complement of zero");
        rd(3, 1, 8'hC0, "R3 toggle any address");
        idle(3);
        rd(0, 0, 8'h00, "R8 program ends");

        // R7: program to protected sector
        prot_i = 4'b0100;
        do_prog(2, 8'h00);
        rd(2, 1, 8'h80, "R7 protected abort status");
        rd(2, 1, 8'hC0, "R7 protected abort toggle");
        rd(2, 1, 8'h80, "R7 protected abort last");
        rd(2, 0, 8'h00, "R7 protected abort return");

        // R4: program timeout
        prot_i = '0;
        fail_i = 1'b1;
        do_prog(1, 8'h80);
        for (int k = 0; k < 5; k++)
            rd(1, 1, (k % 2) ? 8'h40 : 8'h00, "R4 program before limit");
        rd(1, 1, 8'h60, "R4 timeout bit5");
        rd(1, 1, 8'h20, "R4 timeout toggling");
        do_prog(1, 8'h00);
        rd(1, 1, 8'h60, "R4 command ignored in timeout");
        do_reset();
        fail_i = 1'b0;
        rd(1, 0, 8'h00, "R4 reset command returns");

        // R5 R6 R8 R10: sector erase with window extension
        prot_i = 4'b0100;
        array_i = 8'hA5;
        do_erase(0, 0);
        rd(0, 1, 8'h00, "R5 window bit3 low");
        rd(0, 1, 8'h44, "R6 bit2 toggles selected");
        do_erase(0, 3);
        rd(3, 1, 8'h00, "R6 added sector selected");
        rd(1, 1, 8'h40, "R6 unselected bit2 zero");
        rd(3, 1, 8'h04, "R6 bit2 unchanged by unselected");
        rd(0, 1, 8'h40, "R8 window restarted");
        rd(0, 1, 8'h0C, "R5 bit3 high in erase");
        rd(2, 1, 8'h48, "R6 protected sector not selected");
        idle(5);
        rd(0, 1, 8'h08, "R8 erase last cycle");
        rd(0, 0, 8'h00, "R8 erase auto return");

        // R11: program command ends window
        do_erase(0, 1);
        rd(1, 1, 8'h00, "R11 window open");
        do_prog(0, 8'h00);
        rd(1, 0, 8'h00, "R11 program aborts window");
        rd(0, 0, 8'h00, "R11 nothing started");

        // R9: suspend/resume outside erase ignored
        do_resume();
        rd(0, 0, 8'h00, "R9 resume in idle ignored");
        do_susp();
        rd(0, 0, 8'h00, "R9 suspend in idle ignored");

        // R9 R3 R6 R10: chip erase with suspend and resume
        do_erase(1, 0);
        rd(0, 1, 8'h08, "R10 chip erase bit7 low");
        do_susp();
        rd(0, 1, 8'hCC, "R9 suspended status");
        rd(0, 1, 8'hC8, "R3 bit6 held in suspend");
        rd(2, 0, 8'h00, "R6 suspend unselected array");
        rd(1, 1, 8'hCC, "R6 bit2 in suspend");
        idle(3);
        rd(3, 1, 8'hC8, "R9 suspend holds");
        do_resume();
        rd(0, 1, 8'h4C, "R9 resume erases");
        idle(4);
        rd(1, 1, 8'h08, "R8 suspend time excluded");
        rd(1, 0, 8'h00, "R8 resumed erase returns");

        // R7: chip erase with all sectors protected
        prot_i = 4'b1111;
        do_erase(1, 0);
        rd(0, 1, 8'h08, "R7 erase abort status");
        rd(1, 1, 8'h48, "R7 erase abort toggle");
        rd(2, 1, 8'h08, "R7 erase abort last");
        rd(0, 0, 8'h00, "R7 erase abort return");

        // R4 R5: erase timeout
        prot_i = '0;
        fail_i = 1'b1;
        do_erase(0, 1);
        idle(13);
        rd_i = 1'b1; rd_sect_i = 1; #1;
        check("R4 R5 erase timeout bits", {1'b0, dout_o & 8'hA8}, {1'b0, 8'h28});
        @(negedge clk); rd_i = 1'b0;
        do_susp();
        rd_i = 1'b1; rd_sect_i = 1; #1;
        check("R4 suspend ignored in timeout", {stat_o, dout_o & 8'h20}, {1'b1, 8'h20});
        @(negedge clk); rd_i = 1'b0;
        do_reset();
        fail_i = 1'b0;
        rd(1, 0, 8'h00, "R4 erase timeout reset");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule